// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a small read/write cache that sits between a CPU-side request port and a simple memory port. Every block holds a single 32-bit word, and every set holds two ways. Each way stores a valid flag, a tag and the cached word. Each set stores one recency bit that names the way referenced last. A CPU request carries a byte address, a write flag and write data. When the request completes, the block pulses a done strobe together with a hit or a miss indication and, for reads, the data word.

Read hits complete in one cycle and do not stop the request port. A read miss refills the chosen way from memory through a request/ready handshake. The way is picked in this order: an invalid way first (way 0 before way 1), otherwise the way that was not referenced last. Writes go through to memory and do not allocate on a miss. While a memory transaction is outstanding, the block holds busy high and ignores new requests. Two counters record completed hits and completed misses. The set count, the address width and the counter width are parameters.

Top module: `sa2_cache_ctrl`

## Requirements
- R1: After reset every way of every set is invalid, so the first read of any address misses and raises a memory read.
- R2: Address bits [1:0] select a byte inside the word and play no part in lookup. The set index is the next log2(SETS) bits above them, and the tag is all remaining upper bits, compared against both ways of the set.
- R3: A read that is accepted while idle and hits gives cpu_done=1, cpu_hit=1, cpu_miss=0 and the cached word on cpu_rdata in the cycle after acceptance. It raises no memory request and cpu_busy stays 0.
- R4: A read miss drives mem_req=1, mem_we=0 and mem_addr equal to the request address from the cycle after acceptance. These stay stable until mem_ready. In the cycle after the mem_ready cycle, cpu_done=1, cpu_miss=1 and cpu_rdata carries mem_rdata.
- R5: When a set has an invalid way, a miss fills that way, and way 0 is filled when both ways are invalid.
- R6: Every hit or fill records its way as most recent in that set's bit. When both ways are valid, a miss replaces the way that was not referenced most recently.
- R7: With SETS=2, the word sequence 0,4,0,4,0,4,0,4 (byte addresses 0 and 16) after reset gives exactly 2 misses followed by 6 hits.
- R8: Every write drives mem_req=1, mem_we=1, mem_addr and mem_wdata from the request, and completes with a done pulse in the cycle after mem_ready. A write hit updates the cached word and the recency bit. A write miss leaves the cache unchanged.
- R9: cpu_busy is 1 exactly while a memory transaction is outstanding. A request presented while busy is ignored and produces no completion.
- R10: hit_count and miss_count are 0 after reset. Each completed request adds exactly one to the counter that matches its cpu_hit or cpu_miss, in the same cycle as cpu_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; accepted when cpu_busy is 0 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | Memory transaction outstanding |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_hit | output | 1 | Completed request hit |
| cpu_miss | output | 1 | Completed request missed |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done on reads |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = refill read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W | Refill data, valid with mem_ready |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
Results of a read hit are due one clock edge after acceptance. A miss or a write shows mem_req one edge after acceptance, and its completion strobe, result and counter step follow one edge after the mem_ready cycle. The bench drives every input on a falling edge and samples on the following falling edge, so each check falls halfway through the cycle in which the registered result is first visible. Stalls of several cycles with mem_ready low, and a request presented during a stall, show that the outputs hold and that nothing extra completes.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;
   localparam int WAYS       = 2;
   localparam int BYTE_OFF_W = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2
   } ctl_state_t;
endpackage

// File: rtl/sa2_way_store.sv
// One way: valid flags, tags and data words for every set.
module sa2_way_store #(
   parameter int SETS   = 4,
   parameter int TAG_W  = 12,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            tag_q[s]  <= '0;
            data_q[s] <= '0;
         end
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         tag_q[wr_idx]   <= wr_tag;
         data_q[wr_idx]  <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/sa2_tag_match.sv
// Parallel tag compare over all ways, data select after the compare.
module sa2_tag_match #(
   parameter int TAG_W  = 12,
   parameter int DATA_W = 32,
   parameter int WAYS   = 2
) (
   input  logic [WAYS-1:0]   valid,
   input  logic [TAG_W-1:0]  tags  [WAYS],
   input  logic [DATA_W-1:0] words [WAYS],
   input  logic [TAG_W-1:0]  look_tag,
   output logic              hit,
   output logic              hit_way,
   output logic [DATA_W-1:0] hit_data
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid[w] && (tags[w] == look_tag);
   end

   always_comb begin
      hit      = 1'b0;
      hit_way  = 1'b0;
      hit_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            hit      = 1'b1;
            hit_way  = w[0];
            hit_data = words[w];
         end
      end
   end
endmodule

// File: rtl/sa2_victim_pick.sv
// Replacement choice: invalid way first (way 0 before way 1), else not-most-recent.
module sa2_victim_pick (
   input  logic [1:0] valid,
   input  logic       mru_way,
   output logic       victim
);
   always_comb begin
      if (!valid[0])      victim = 1'b0;
      else if (!valid[1]) victim = 1'b1;
      else                victim = ~mru_way;
   end
endmodule

// File: rtl/sa2_stat_counters.sv
module sa2_stat_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_evt,
   input  logic             miss_evt,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         if (hit_evt)  hit_count  <= hit_count + 1'b1;
         if (miss_evt) miss_count <= miss_count + 1'b1;
      end
   end
endmodule

// File: rtl/sa2_cache_ctrl.sv
module sa2_cache_ctrl
   import sa2_cache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SETS   = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic              cpu_miss,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - BYTE_OFF_W - IDX_W;
   localparam int IDX_LO = BYTE_OFF_W;
   localparam int TAG_LO = BYTE_OFF_W + IDX_W;

   // elaboration-time parameter checks
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two and at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32 to match the 2-bit byte offset");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   ctl_state_t        state_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic              req_hit_q;
   logic [SETS-1:0]   mru_q;

   logic              accept;
   logic [ADDR_W-1:0] look_addr;
   logic [IDX_W-1:0]  look_idx;
   logic [TAG_W-1:0]  look_tag;

   logic [WAYS-1:0]   way_valid;
   logic [TAG_W-1:0]  way_tag  [WAYS];
   logic [DATA_W-1:0] way_data [WAYS];
   logic [WAYS-1:0]   way_wr;
   logic [DATA_W-1:0] wr_word;

   logic              lookup_hit;
   logic              hit_way;
   logic [DATA_W-1:0] hit_data;
   logic              victim;

   logic              fill_done;
   logic              write_done;
   logic              rd_hit_now;
   logic              hit_next;
   logic              miss_next;

   assign accept     = cpu_req && (state_q == ST_IDLE);
   assign look_addr  = (state_q == ST_IDLE) ? cpu_addr : req_addr_q;
   assign look_idx   = look_addr[TAG_LO-1:IDX_LO];
   assign look_tag   = look_addr[ADDR_W-1:TAG_LO];

   assign fill_done  = (state_q == ST_FILL)  && mem_ready;
   assign write_done = (state_q == ST_WRITE) && mem_ready;
   assign rd_hit_now = accept && !cpu_we && lookup_hit;

   assign wr_word = (state_q == ST_FILL) ? mem_rdata : cpu_wdata;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_wr[w] = (accept && cpu_we && lookup_hit && (hit_way == w[0]))
                       || (fill_done && (victim == w[0]));

      sa2_way_store #(
         .SETS   (SETS),
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W)
      ) u_store (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (look_idx),
         .rd_valid (way_valid[w]),
         .rd_tag   (way_tag[w]),
         .rd_data  (way_data[w]),
         .wr_en    (way_wr[w]),
         .wr_idx   (look_idx),
         .wr_tag   (look_tag),
         .wr_data  (wr_word)
      );
   end

   sa2_tag_match #(
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .WAYS   (WAYS)
   ) u_match (
      .valid    (way_valid),
      .tags     (way_tag),
      .words    (way_data),
      .look_tag (look_tag),
      .hit      (lookup_hit),
      .hit_way  (hit_way),
      .hit_data (hit_data)
   );

   sa2_victim_pick u_victim (
      .valid   (way_valid),
      .mru_way (mru_q[look_idx]),
      .victim  (victim)
   );

   // control sequence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_addr_q  <= '0;
         req_wdata_q <= '0;
         req_hit_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               req_addr_q  <= cpu_addr;
               req_wdata_q <= cpu_wdata;
               req_hit_q   <= lookup_hit;
               if (cpu_we)           state_q <= ST_WRITE;
               else if (!lookup_hit) state_q <= ST_FILL;
            end
            ST_FILL:  if (mem_ready) state_q <= ST_IDLE;
            ST_WRITE: if (mem_ready) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // per-set recency bit: holds the way referenced last
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mru_q <= '0;
      end else if (accept && lookup_hit) begin
         mru_q[look_idx] <= hit_way;
      end else if (fill_done) begin
         mru_q[look_idx] <= victim;
      end
   end

   assign hit_next  = rd_hit_now || (write_done && req_hit_q);
   assign miss_next = fill_done  || (write_done && !req_hit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_done  <= 1'b0;
         cpu_hit   <= 1'b0;
         cpu_miss  <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_done <= hit_next || miss_next;
         cpu_hit  <= hit_next;
         cpu_miss <= miss_next;
         if (rd_hit_now)     cpu_rdata <= hit_data;
         else if (fill_done) cpu_rdata <= mem_rdata;
      end
   end

   sa2_stat_counters #(
      .CNT_W (CNT_W)
   ) u_stats (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_evt    (hit_next),
      .miss_evt   (miss_next),
      .hit_count  (hit_count),
      .miss_count (miss_count)
   );

   assign cpu_busy  = (state_q != ST_IDLE);
   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_addr  = req_addr_q;
   assign mem_wdata = req_wdata_q;
endmodule

// File: rtl/sa2_cache_chk.sv
module sa2_cache_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_busy,
   input logic              cpu_done,
   input logic              cpu_hit,
   input logic              cpu_miss,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready,
   input logic              lookup_hit,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);
   // R3
   read_hit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_busy && !cpu_we && lookup_hit) |=> (cpu_done && cpu_hit && !mem_req));

   // R3
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_hit, cpu_miss}) && ((cpu_hit || cpu_miss) == cpu_done));

   // R9
   busy_on_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_busy);

   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R10
   hit_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (hit_count == $past(hit_count) + 1'b1));

   // R10
   miss_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_miss |-> (miss_count == $past(miss_count) + 1'b1));

   // R10
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_done |=> ($stable(hit_count) || cpu_hit));
endmodule

bind sa2_cache_ctrl sa2_cache_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_we     (cpu_we),
   .cpu_busy   (cpu_busy),
   .cpu_done   (cpu_done),
   .cpu_hit    (cpu_hit),
   .cpu_miss   (cpu_miss),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_ready  (mem_ready),
   .lookup_hit (lookup_hit),
   .hit_count  (hit_count),
   .miss_count (miss_count)
);

// File: tb/sa2_cache_ctrl_bench.sv
module sa2_cache_ctrl_bench;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_busy, cpu_done, cpu_hit, cpu_miss;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ready = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic [CW-1:0] hit_count, miss_count;

   int n_chk = 0;
   int n_bad = 0;
   int exp_h = 0;
   int exp_m = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sa2_cache_ctrl #(.ADDR_W(AW), .SETS(2), .DATA_W(DW), .CNT_W(CW)) u_sa2_cache_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
      .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_miss(cpu_miss),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
   );

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return 32'hA500_0000 | 32'(a);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic chk_counts(input string rq);
      chk(hit_count == CW'(exp_h), {rq, " hit_count"}, 32'(hit_count), 32'(exp_h));
      chk(miss_count == CW'(exp_m), {rq, " miss_count"}, 32'(miss_count), 32'(exp_m));
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_req = 1'b0; mem_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_h = 0; exp_m = 0;
      @(negedge clk);
   endtask

   // read one address; miss path refills with rdata after stall idle cycles
   task automatic do_read(input logic [AW-1:0] a, input bit exp_hit,
                          input logic [DW-1:0] d, input int stall, input string rq);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      if (exp_hit) begin
         exp_h++;
         chk(cpu_done && cpu_hit && !cpu_miss, {rq, " hit strobe"}, {29'd0, cpu_done, cpu_hit, cpu_miss}, 32'b110);
         chk(cpu_rdata == d, {rq, " hit data"}, cpu_rdata, d);
         chk(!mem_req && !cpu_busy, {rq, " R3 no mem/busy"}, {30'd0, mem_req, cpu_busy}, 32'd0);
      end else begin
         chk(mem_req && !mem_we && cpu_busy && !cpu_done, {rq, " R4 refill req"},
             {28'd0, mem_req, mem_we, cpu_busy, cpu_done}, 32'b1010);
         chk(mem_addr == a, {rq, " R4 refill addr"}, 32'(mem_addr), 32'(a));
         repeat (stall) @(negedge clk);
         if (stall > 0)
            chk(mem_req && mem_addr == a && !cpu_done, {rq, " R4 hold"}, 32'(mem_addr), 32'(a));
         mem_ready = 1'b1; mem_rdata = d;
         @(negedge clk);
         mem_ready = 1'b0;
         exp_m++;
         chk(cpu_done && cpu_miss && !cpu_hit, {rq, " miss strobe"}, {29'd0, cpu_done, cpu_hit, cpu_miss}, 32'b101);
         chk(cpu_rdata == d, {rq, " R4 refill data"}, cpu_rdata, d);
         chk(!cpu_busy && !mem_req, {rq, " R9 busy drop"}, {30'd0, cpu_busy, mem_req}, 32'd0);
      end
      chk_counts({rq, " R10"});
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit exp_hit, input string rq);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      chk(mem_req && mem_we && cpu_busy, {rq, " R8 mem write"}, {29'd0, mem_req, mem_we, cpu_busy}, 32'b111);
      chk(mem_addr == a && mem_wdata == d, {rq, " R8 write payload"}, mem_wdata, d);
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      if (exp_hit) exp_h++; else exp_m++;
      chk(cpu_done && cpu_hit == exp_hit && cpu_miss == !exp_hit, {rq, " R8 write done"},
          {29'd0, cpu_done, cpu_hit, cpu_miss}, {29'd0, 1'b1, exp_hit, !exp_hit});
      chk_counts({rq, " R10"});
   endtask

   task automatic t_reset_state();
      chk(!cpu_busy && !cpu_done && !mem_req, "R9 reset idle", {29'd0, cpu_busy, cpu_done, mem_req}, 32'd0);
      chk_counts("R10 reset");
   endtask

   task automatic t_pingpong();
      for (int i = 0; i < 8; i++) begin
         logic [AW-1:0] a;
         a = (i % 2 == 0) ? 12'd0 : 12'd16;
         do_read(a, i >= 2, pat(a), 0, "R7 R1 R5 pingpong");
      end
      chk(hit_count == 6 && miss_count == 2, "R7 totals", {hit_count, miss_count}, {16'd6, 16'd2});
   endtask

   task automatic t_offset();
      do_read(12'd2, 1'b1, pat(12'd0), 0, "R2 byte offset ignored");
      do_read(12'd7, 1'b0, pat(12'd4), 0, "R2 other set");
      do_read(12'd5, 1'b1, pat(12'd4), 0, "R2 other set hit");
   endtask

   task automatic t_lru();
      // set 0 holds 0 (way0, last used) and 16
      do_read(12'd32, 1'b0, pat(12'd32), 2, "R6 evict 16");
      do_read(12'd0,  1'b1, pat(12'd0),  0, "R6 keep 0");
      do_read(12'd16, 1'b0, pat(12'd16), 0, "R6 16 was evicted");
      do_read(12'd32, 1'b0, pat(12'd32), 0, "R6 32 was evicted");
      do_read(12'd16, 1'b1, pat(12'd16), 0, "R6 16 kept");
      do_read(12'd0,  1'b0, pat(12'd0),  0, "R6 0 was evicted");
   endtask

   task automatic t_write();
      do_write(12'd0, 32'hCAFE_0001, 1'b1, "R8 write hit");
      do_read(12'd0, 1'b1, 32'hCAFE_0001, 0, "R8 updated word");
      do_write(12'd48, 32'h1234_5678, 1'b0, "R8 write miss");
      do_read(12'd16, 1'b1, pat(12'd16), 0, "R8 no allocate keeps 16");
      do_read(12'd0,  1'b1, 32'hCAFE_0001, 0, "R8 no allocate keeps 0");
      do_read(12'd48, 1'b0, pat(12'd48), 0, "R8 48 not cached");
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 12'd64;
      @(negedge clk);
      cpu_addr = 12'd48;   // request while busy
      @(negedge clk);
      cpu_req = 1'b0;
      chk(cpu_busy && mem_addr == 12'd64 && !cpu_done, "R9 ignored while busy", 32'(mem_addr), 32'd64);
      chk_counts("R9 counts frozen");
      mem_ready = 1'b1; mem_rdata = pat(12'd64);
      @(negedge clk);
      mem_ready = 1'b0;
      exp_m++;
      chk(cpu_done && cpu_miss && cpu_rdata == pat(12'd64), "R9 own request done", cpu_rdata, pat(12'd64));
      @(negedge clk);
      chk(!cpu_done && !mem_req, "R9 no extra completion", {30'd0, cpu_done, mem_req}, 32'd0);
      chk_counts("R9 R10 after ignore");
   endtask

   task automatic t_rereset();
      apply_reset();
      chk_counts("R10 cleared by reset");
      do_read(12'd64, 1'b0, pat(12'd64), 0, "R1 invalid after reset");
   endtask

   initial begin
      apply_reset();
      t_reset_state();
      t_pingpong();
      t_offset();
      t_lru();
      t_write();
      t_busy_ignore();
      t_rereset();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule